// File: doc/BRIEF.md
# Half-Stored Scratchpad with On-Demand Recompute

This block builds a scratchpad of chained states and then answers random reads from it. A fill begins from a seed. Every later state is the one before it run once through a mixing step. The logical sequence has `ENTRIES` states, 1024 by default. Only the even-numbered states go into RAM, so the RAM is `ENTRIES/2` words deep. The physical address is the logical index shifted right by one.

A read of an even index comes straight from RAM. A read of an odd index fetches the even state just below it, then runs it through the mixer once more. Odd reads therefore cost one extra mixer interval. That is the price for halving the storage. Only one read can be in flight at a time, and `busy` shows when the block cannot accept a command. A read that arrives before any fill has finished is refused with an error response.

The mixer here is a placeholder step that takes several cycles, not a real cipher core. It computes `y = rotl(x,5) XOR (x + 0x9E3779B9)`, truncated to the data width, and holds its result for `MIX_CYCLES` clocks.

Top module: `lg_scratchpad`

## Requirements
- R1: After reset, `busy`, `filled` and `rsp_valid` are 0.
- R2: A `fill_start` accepted while idle keeps `busy` high for exactly (ENTRIES-1)*(MIX_CYCLES+1) cycles. `filled` then reads 1, and logical state i equals the mixing step applied i times to `fill_seed`, where the step is y = rotl(x,5) XOR (x + 0x9E3779B9) mod 2^W.
- R3: An accepted read of an even index has `rsp_valid` high with `rsp_err`=0 in the first cycle after the accepting clock edge. `rsp_data` is then logical state `rd_idx`.
- R4: An accepted read of an odd index n raises `rsp_valid` in cycle MIX_CYCLES+2 after the accepting edge and not earlier. `rsp_data` is then the mixing step applied once to state n-1. This holds for the last index, ENTRIES-1.
- R5: From acceptance until its response, a read keeps `busy` high. Any `rd_req` made while `busy` is high is dropped and produces no response, and each accepted read yields exactly one response pulse.
- R6: While `filled` is 0 and the block is idle, a `rd_req` yields `rsp_valid`=1 and `rsp_err`=1 with `rsp_data`=0 in the first cycle after the request edge.
- R7: `fill_start` while `busy` is ignored, and the stored contents stay unchanged. When `fill_start` and `rd_req` come in the same idle cycle, the fill is taken and the read is dropped with no response.
- R8: A fill accepted after an earlier one drops `filled` to 0 during the fill. It then replaces every state with the chain from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_start | input | 1 | Start a fill from `fill_seed` |
| fill_seed | input | W | Logical state 0 of the chain |
| filled | output | 1 | A complete fill is held in the scratchpad |
| rd_req | input | 1 | Read request |
| rd_idx | input | log2(ENTRIES) | Logical index to read |
| busy | output | 1 | Fill or read in progress; commands are not accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a refusal (no fill yet) |
| rsp_data | output | W | Response data, 0 when not valid or refused |

## Verification
Several behaviours are checked by the assertions on every clock. A refused read must produce a flagged response on the next cycle, and an even read must answer on the next cycle. An odd read must stay silent and busy through that same cycle. A data response must be followed by a quiet cycle. Accepting a fill must clear `filled`, and `filled` must otherwise hold. The mixer must never be restarted while it is working. Other behaviours need the bench's scenarios: whether the stored and recomputed values actually equal the chained mixing of the seed, the exact fill duration, the odd-read latency, and the effect of refills and dropped commands. The bench sweeps every logical index of a small configuration under two seeds for these.

// File: rtl/lg_pkg.sv
package lg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RMEM = 2'd2,
    ST_RMIX = 2'd3
  } lg_state_e;

endpackage

// File: rtl/lg_mixer.sv
module lg_mixer #(
  parameter int W          = 32,
  parameter int MIX_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic         done,
  output logic [W-1:0] dout,
  output logic         running
);
  localparam int CW = $clog2(MIX_CYCLES + 1);

  // placeholder mixing step: rotate left by 5, xor with offset sum
  function automatic logic [W-1:0] mix_fn(input logic [W-1:0] x);
    mix_fn = {x[W-6:0], x[W-1:W-5]} ^ (x + W'(32'h9E3779B9));
  endfunction

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W-1:0]  res_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q && (cnt_q == '0);
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= CW'(MIX_CYCLES - 1);
        res_q <= mix_fn(din);
      end else if (run_q) begin
        if (cnt_q == '0) run_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign done    = done_q;
  assign dout    = res_q;
  assign running = run_q;

  AST_MIX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) start |-> !run_q); // R4

endmodule

// File: rtl/lg_store.sv
module lg_store #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lg_scratchpad.sv
module lg_scratchpad #(
  parameter int W          = 32,
  parameter int ENTRIES    = 1024,
  parameter int MIX_CYCLES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill_start,
  input  logic [W-1:0]               fill_seed,
  output logic                       filled,
  input  logic                       rd_req,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic                       busy,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [W-1:0]               rsp_data
);
  import lg_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int DEPTH = ENTRIES / 2;
  localparam int AW    = $clog2(DEPTH);

  lg_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;
  logic             odd_q;
  logic             err_q;
  logic             filled_q;

  // named internal events
  logic acc_fill, acc_rd, rej_rd;
  logic fill_step, fill_last;
  logic mix_start, mix_done, mix_run;
  logic [W-1:0] mix_in, mix_out;
  logic st_we;
  logic [AW-1:0] st_waddr;
  logic [W-1:0]  st_wdata, st_rdata;

  assign busy      = (state_q != ST_IDLE);
  assign acc_fill  = fill_start && !busy;
  assign acc_rd    = rd_req && !busy && !fill_start && filled_q;
  assign rej_rd    = rd_req && !busy && !fill_start && !filled_q;
  assign idx_nxt   = idx_q + 1'b1;
  assign fill_step = (state_q == ST_FILL) && mix_done;
  assign fill_last = fill_step && (idx_q == IDX_W'(ENTRIES - 2));

  assign mix_start = acc_fill || (fill_step && !fill_last) ||
                     ((state_q == ST_RMEM) && odd_q);
  assign mix_in    = acc_fill ? fill_seed :
                     ((state_q == ST_RMEM) ? st_rdata : mix_out);

  // even logical states land at address index/2
  assign st_we    = acc_fill || (fill_step && idx_q[0]);
  assign st_waddr = acc_fill ? '0 : idx_nxt[IDX_W-1:1];
  assign st_wdata = acc_fill ? fill_seed : mix_out;

  lg_mixer #(.W(W), .MIX_CYCLES(MIX_CYCLES)) mixer_i (
    .clk(clk), .rst_n(rst_n), .start(mix_start), .din(mix_in),
    .done(mix_done), .dout(mix_out), .running(mix_run)
  );

  lg_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .re(acc_rd), .raddr(rd_idx[IDX_W-1:1]), .rdata(st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      odd_q    <= 1'b0;
      err_q    <= 1'b0;
      filled_q <= 1'b0;
    end else begin
      err_q <= rej_rd;
      case (state_q)
        ST_IDLE: begin
          if (acc_fill) begin
            state_q  <= ST_FILL;
            idx_q    <= '0;
            filled_q <= 1'b0;
          end else if (acc_rd) begin
            state_q <= ST_RMEM;
            odd_q   <= rd_idx[0];
          end
        end
        ST_FILL: begin
          if (fill_step) begin
            idx_q <= idx_nxt;
            if (fill_last) begin
              state_q  <= ST_IDLE;
              filled_q <= 1'b1;
            end
          end
        end
        ST_RMEM: state_q <= odd_q ? ST_RMIX : ST_IDLE;
        ST_RMIX: if (mix_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic even_rsp, odd_rsp;
  assign even_rsp = (state_q == ST_RMEM) && !odd_q;
  assign odd_rsp  = (state_q == ST_RMIX) && mix_done;

  always_comb begin
    rsp_valid = err_q || even_rsp || odd_rsp;
    rsp_err   = err_q;
    rsp_data  = '0;
    if (even_rsp)     rsp_data = st_rdata;
    else if (odd_rsp) rsp_data = mix_out;
  end

  assign filled = filled_q;

  AST_REFUSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) rej_rd |=> (rsp_valid && rsp_err)); // R6
  AST_EVEN_NEXT:      assert property (@(posedge clk) disable iff (!rst_n) (acc_rd && !rd_idx[0]) |=> (rsp_valid && !rsp_err)); // R3
  AST_ODD_NOT_EARLY:  assert property (@(posedge clk) disable iff (!rst_n) (acc_rd && rd_idx[0]) |=> (!rsp_valid && busy)); // R4
  AST_ONE_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_err) |=> !rsp_valid); // R5
  AST_FILL_CLEARS:    assert property (@(posedge clk) disable iff (!rst_n) acc_fill |=> (busy && !filled)); // R8
  AST_FILLED_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n) (filled && !acc_fill) |=> filled); // R2

endmodule

// File: tb/lg_scratchpad_tb_top.sv
module lg_scratchpad_tb_top;
  localparam int W  = 32;
  localparam int N  = 32;
  localparam int MC = 3;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fill_start = 1'b0;
  logic [W-1:0]  fill_seed = '0;
  logic          filled;
  logic          rd_req = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic          busy, rsp_valid, rsp_err;
  logic [W-1:0]  rsp_data;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [W-1:0] model [N];

  always #10 clk = ~clk;

  lg_scratchpad #(.W(W), .ENTRIES(N), .MIX_CYCLES(MC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_seed(fill_seed),
    .filled(filled), .rd_req(rd_req), .rd_idx(rd_idx), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  function automatic logic [W-1:0] step_ref(input logic [W-1:0] x);
    logic [2*W-1:0] dbl;
    dbl = {x, x};
    return dbl[58:27] ^ (x + 32'h9E3779B9);
  endfunction

  task automatic build(input logic [W-1:0] seed);
    model[0] = seed;
    for (int i = 1; i < N; i++) model[i] = step_ref(model[i-1]);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [W-1:0] seed, input bit with_rd, output int cyc, output int rsps);
    @(negedge clk);
    fill_start = 1'b1; fill_seed = seed;
    if (with_rd) begin rd_req = 1'b1; rd_idx = 0; end
    @(negedge clk);
    fill_start = 1'b0; rd_req = 1'b0;
    cyc = 0; rsps = 0;
    while (busy && cyc < 50000) begin
      if (rsp_valid) rsps++;
      cyc++;
      @(negedge clk);
    end
    if (rsp_valid) rsps++;
  endtask

  task automatic do_read(input int idx, output logic [W-1:0] d, output logic e, output int lat);
    @(negedge clk);
    rd_req = 1'b1; rd_idx = IW'(idx);
    @(negedge clk);
    rd_req = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    d = rsp_data; e = rsp_err;
  endtask

  task automatic sweep(input string tag);
    logic [W-1:0] d; logic e; int lat;
    for (int i = 0; i < N; i++) begin
      do_read(i, d, e, lat);
      if (i % 2 == 0) begin
        chk(d == model[i] && !e, "R3", {tag, " even data"}, d, model[i]);
        chk(lat == 1, "R3", {tag, " even latency"}, W'(lat), 1);
      end else begin
        chk(d == model[i] && !e, "R4", {tag, " odd data"}, d, model[i]);
        chk(lat == MC + 2, "R4", {tag, " odd latency"}, W'(lat), W'(MC + 2));
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] d; logic e; int lat, cyc, rsps;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", W'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", W'(busy), 0);
    chk(filled == 1'b0, "R1", "filled after reset", W'(filled), 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", W'(rsp_valid), 0);

    // R6: read before any fill
    do_read(2, d, e, lat);
    chk(e == 1'b1 && lat == 1, "R6", "refusal flag/latency", W'(lat), 1);
    chk(d == '0, "R6", "refusal data", d, 0);
    do_read(7, d, e, lat);
    chk(e == 1'b1 && lat == 1, "R6", "refusal odd index", W'(e), 1);

    // R2: first fill
    build(32'h1234_5678);
    do_fill(32'h1234_5678, 1'b0, cyc, rsps);
    chk(cyc == (N - 1) * (MC + 1), "R2", "fill duration", W'(cyc), W'((N - 1) * (MC + 1)));
    chk(filled == 1'b1, "R2", "filled after fill", W'(filled), 1);
    sweep("seedA");

    // R5: request while busy is dropped
    @(negedge clk);
    rd_req = 1'b1; rd_idx = 3;
    @(negedge clk);
    rd_idx = 4;
    rsps = 0; d = '0;
    for (int k = 0; k < 20; k++) begin
      if (k == 2) rd_req = 1'b0;
      if (k < MC + 1) chk(busy == 1'b1, "R5", "busy while outstanding", W'(busy), 1);
      if (rsp_valid) begin rsps++; d = rsp_data; end
      @(negedge clk);
    end
    chk(rsps == 1, "R5", "one response only", W'(rsps), 1);
    chk(d == model[3], "R5", "response of accepted read", d, model[3]);

    // R7: fill_start while busy ignored
    @(negedge clk);
    rd_req = 1'b1; rd_idx = 5;
    @(negedge clk);
    rd_req = 1'b0; fill_start = 1'b1; fill_seed = 32'hDEAD_BEEF;
    @(negedge clk);
    fill_start = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data == model[5], "R7", "read during ignored fill", rsp_data, model[5]);
    @(negedge clk);
    chk(busy == 1'b0 && filled == 1'b1, "R7", "no fill started", W'(busy), 0);
    do_read(6, d, e, lat);
    chk(d == model[6], "R7", "contents kept", d, model[6]);
    do_read(N - 1, d, e, lat);
    chk(d == model[N-1], "R4", "last index", d, model[N-1]);

    // R7/R8: fill and read in the same idle cycle, refill with new seed
    build(32'hCAFE_0001);
    @(negedge clk);
    fill_start = 1'b1; fill_seed = 32'hCAFE_0001; rd_req = 1'b1; rd_idx = 0;
    @(negedge clk);
    fill_start = 1'b0; rd_req = 1'b0;
    chk(filled == 1'b0, "R8", "filled cleared on refill", W'(filled), 0);
    rsps = 0; cyc = 0;
    while (busy && cyc < 50000) begin
      if (rsp_valid) rsps++;
      cyc++;
      @(negedge clk);
    end
    chk(rsps == 0, "R7", "simultaneous read dropped", W'(rsps), 0);
    chk(cyc == (N - 1) * (MC + 1), "R8", "refill duration", W'(cyc), W'((N - 1) * (MC + 1)));
    chk(filled == 1'b1, "R8", "filled after refill", W'(filled), 1);
    sweep("seedB");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule